// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting time and demanding to be serviced inside a window. A free-running up-counter, 32 bits wide, advances once per prescaler period while the watchdog is enabled. Software services it with a two-write sequence to a dedicated register. A service that lands before the early threshold is a fault, and so is a counter that reaches the late threshold without being serviced. Either fault latches a sticky flag that software must clear.

Each fault can drive a level interrupt, a one-cycle reset request, or both, depending on two enable bits. The register port is a plain synchronous write strobe with a write address and data, plus a separate combinational read address and data. Both thresholds are powers of two that are picked by a 4-bit exponent offset from a parameterised base, which is 16 by default. The prescaler divides by a power of two from 1 to 32768.

Register addresses: 0 control, 1 window, 2 service, 3 status, 4 counter (read only). Other addresses read as zero.

Top module: `wwdt_core`

## Requirements
- R1: While control bit 0 (enable) is 0, the counter and prescaler are held at 0, a service sequence has no effect on the counter or flags, and no fault is raised.
- R2: With enable set and control bits [7:4] holding n, the counter (address 4) advances by exactly one every 2^n clock cycles.
- R3: A service is recognised only when a write of low byte 0xA5 to address 2 is followed by a write of low byte 0x5A to address 2. Any other write to address 2 in between breaks the sequence. Writes to other addresses do not break it. Address 2 reads back in bit 0 whether the 0xA5 has been seen.
- R4: A recognised service clears the counter and the prescaler to 0 at the clock edge that takes the 0x5A write.
- R5: With window bits [11:8] holding L, status bit 1 (late fault) sets at the edge where the counter becomes 2^(L+BASE).
- R6: With window bits [3:0] holding E, a recognised service while the counter is below 2^(E+BASE) sets status bit 0 (early fault). A service at or above that value sets no flag.
- R7: Both status flags stay set until software writes a 1 to that bit of address 3. If a fault and a clear happen in the same cycle, the fault wins.
- R8: The interrupt output equals control bit 8 ANDed with the OR of the two status flags.
- R9: When control bit 9 is set, the reset request pulses high for one cycle, in the cycle where a fault flag first reads set from a new fault event.
- R10: Address 0 reads {22'b0, bit9, bit8, n[3:0], 3'b0, enable}, address 1 reads {20'b0, L, 4'b0, E}, and after reset every address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong count or prescaler phase shows at address 4 within one prescaler period and moves the late fault to the wrong cycle. A lost or wrongly accepted 0xA5 shows first at the bit 0 readback of address 2, and then as a counter that is not cleared. A bad flag register shows at irq in the same cycle and at rst_req in the cycle after the event. Because of this, the bench compares every output and the selected read data on every clock cycle against a behavioural model.

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 32,
  parameter int PSC_W    = 4,
  parameter int THR_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              rst_req
);
  localparam int PRE_W = (1 << PSC_W) - 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(4);

  logic             en, irq_en, rst_en, arm, flag_early, flag_late;
  logic [PSC_W-1:0] psc, ek, lk;
  logic [PRE_W-1:0] pre, mask;
  logic [CNT_W-1:0] cnt, early_lim, late_lim;
  logic             wr_ctrl, wr_win, wr_svc, wr_stat;
  logic             kick, tick, early_evt, late_evt;

  assign wr_ctrl = wr_en && wr_addr == A_CTRL;
  assign wr_win  = wr_en && wr_addr == A_WIN;
  assign wr_svc  = wr_en && wr_addr == A_SVC;
  assign wr_stat = wr_en && wr_addr == A_STAT;

  logic [PRE_W:0] mask_w;
  assign mask_w    = ((PRE_W+1)'(1) << psc) - (PRE_W+1)'(1);
  assign mask      = mask_w[PRE_W-1:0];
  assign early_lim = CNT_W'(1) << (CNT_W'(ek) + CNT_W'(THR_BASE));
  assign late_lim  = CNT_W'(1) << (CNT_W'(lk) + CNT_W'(THR_BASE));

  assign kick      = en && wr_svc && wr_data[7:0] == 8'h5A && arm;
  assign tick      = en && (pre & mask) == mask;
  assign late_evt  = tick && !kick && cnt == late_lim - CNT_W'(1);
  assign early_evt = kick && cnt < early_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; irq_en <= 1'b0; rst_en <= 1'b0; psc <= '0;
      ek <= '0; lk <= '0;
    end else begin
      if (wr_ctrl) begin
        en     <= wr_data[0];
        psc    <= wr_data[7:4];
        irq_en <= wr_data[8];
        rst_en <= wr_data[9];
      end
      if (wr_win) begin
        ek <= wr_data[3:0];
        lk <= wr_data[11:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (!en || kick) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
      if (tick) cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) arm <= 1'b0;
    else if (wr_svc) arm <= wr_data[7:0] == 8'hA5;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_early <= 1'b0;
      flag_late  <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      flag_early <= early_evt || (flag_early && !(wr_stat && wr_data[0]));
      flag_late  <= late_evt  || (flag_late  && !(wr_stat && wr_data[1]));
      rst_req    <= rst_en && (early_evt || late_evt);
    end
  end

  assign irq = irq_en && (flag_early || flag_late);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {22'd0, rst_en, irq_en, psc, 3'd0, en};
      A_WIN:   rd_data = {20'd0, lk, 4'd0, ek};
      A_SVC:   rd_data = {31'd0, arm};
      A_STAT:  rd_data = {30'd0, flag_late, flag_early};
      A_CNT:   rd_data = 32'(cnt);
      default: rd_data = 32'd0;
    endcase
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> cnt == '0 && !rst_req); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) en && !kick |=> cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) kick |=> cnt == '0 && pre == '0); // R4
  AST_LATE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_late) |-> cnt == $past(late_lim)); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) flag_early && !(wr_stat && wr_data[0]) |=> flag_early); // R7
  AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> flag_early || flag_late); // R9
endmodule

// File: tb/wwdt_core_bench.sv
`timescale 1ns/1ps
module wwdt_core_bench;
  localparam int BASE = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq, rst_req;
  int compared = 0, mismatched = 0, cyc = 0;
  string phase = "R10";

  wwdt_core #(.THR_BASE(BASE)) u_wwdt_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req));

  always #2.5 clk = ~clk;

  bit m_en, m_ie, m_re, m_arm, m_fe, m_fl, m_rst;
  int m_psc, m_ek, m_lk;
  longint m_pre, m_cnt;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_re = 0; m_arm = 0; m_fe = 0; m_fl = 0; m_rst = 0;
      m_psc = 0; m_ek = 0; m_lk = 0; m_pre = 0; m_cnt = 0;
    end else begin
      bit kick, tick, le, ee;
      longint mask;
      kick = m_en && wr_en && wr_addr == 2 && wr_data[7:0] == 8'h5A && m_arm;
      mask = (longint'(1) << m_psc) - 1;
      tick = m_en && ((m_pre & mask) == mask);
      le = tick && !kick && m_cnt == (longint'(1) << (m_lk + BASE)) - 1;
      ee = kick && m_cnt < (longint'(1) << (m_ek + BASE));
      m_rst = m_re && (le || ee);
      if (wr_en && wr_addr == 3) begin
        if (wr_data[0]) m_fe = 0;
        if (wr_data[1]) m_fl = 0;
      end
      if (ee) m_fe = 1;
      if (le) m_fl = 1;
      if (!m_en || kick) begin m_pre = 0; m_cnt = 0; end
      else begin
        m_pre = (m_pre + 1) % 32768;
        if (tick) m_cnt = (m_cnt + 1) % (longint'(1) << 32);
      end
      if (wr_en && wr_addr == 2) m_arm = wr_data[7:0] == 8'hA5;
      if (wr_en && wr_addr == 0) begin
        m_en = wr_data[0]; m_psc = int'(wr_data[7:4]); m_ie = wr_data[8]; m_re = wr_data[9];
      end
      if (wr_en && wr_addr == 1) begin m_ek = int'(wr_data[3:0]); m_lk = int'(wr_data[11:8]); end
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {22'd0, m_re, m_ie, 4'(m_psc), 3'd0, m_en};
      3'd1: return {20'd0, 4'(m_lk), 4'd0, 4'(m_ek)};
      3'd2: return {31'd0, m_arm};
      3'd3: return {30'd0, m_fl, m_fe};
      3'd4: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check({phase, " irq (R8)"}, {31'd0, irq}, {31'd0, m_ie && (m_fe || m_fl)});
      check({phase, " rst_req (R9)"}, {31'd0, rst_req}, {31'd0, m_rst});
      check({phase, " rd_data"}, rd_data, m_read(rd_addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    rd_addr = a; #1; check(tag, rd_data, exp);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 5; a++) rd_chk("R10 reset value", 3'(a), 32'd0);
    wr(3'd1, 32'h0000_0200);
    wr(3'd0, 32'h0000_0320);
    rd_chk("R10 ctrl readback", 3'd0, 32'h0000_0320);
    rd_chk("R10 window readback", 3'd1, 32'h0000_0200);
    phase = "R1"; rd_addr = 3'd4; idle(20);
    rd_chk("R1 count held while off", 3'd4, 32'd0);
    phase = "R2"; wr(3'd0, 32'h0000_0321); idle(21);
    rd_chk("R2 psc=2 count after 22 cycles", 3'd4, 32'd5);
    phase = "R6";
    wr(3'd2, 32'hA5); wr(3'd2, 32'h5A);
    check("R9 pulse on early fault", {31'd0, rst_req}, 32'd1);
    rd_chk("R6 early flag", 3'd3, 32'd1);
    rd_chk("R4 count cleared", 3'd4, 32'd0);
    idle(1);
    check("R9 pulse is one cycle", {31'd0, rst_req}, 32'd0);
    phase = "R7"; rd_addr = 3'd3; idle(5);
    rd_chk("R7 early flag sticky", 3'd3, 32'd1);
    wr(3'd3, 32'd3);
    rd_chk("R7 flags cleared", 3'd3, 32'd0);
    check("R8 irq low after clear", {31'd0, irq}, 32'd0);
    phase = "R3"; rd_addr = 3'd4;
    wr(3'd2, 32'hA5);
    rd_chk("R3 armed readback", 3'd2, 32'd1);
    wr(3'd2, 32'h11); wr(3'd2, 32'h5A);
    rd_chk("R3 broken sequence no fault", 3'd3, 32'd0);
    wr(3'd2, 32'hA5); wr(3'd3, 32'd0); wr(3'd2, 32'h5A);
    rd_chk("R3 interleaved write keeps sequence", 3'd3, 32'd1);
    wr(3'd3, 32'd1);
    phase = "R2"; wr(3'd0, 32'h0000_0301); rd_addr = 3'd4; idle(10);
    wr(3'd0, 32'h0000_0321);
    phase = "R6"; wr(3'd2, 32'hA5); wr(3'd2, 32'h5A);
    wr(3'd3, 32'd3);
    idle(80);
    wr(3'd2, 32'hA5); wr(3'd2, 32'h5A);
    rd_chk("R6 in-window service clean", 3'd3, 32'd0);
    rd_chk("R4 cleared by clean service", 3'd4, 32'd0);
    phase = "R5"; rd_addr = 3'd3;
    begin
      bit seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
        @(negedge clk); #1;
        if (irq) begin
          seen = 1;
          check("R5 late flag", rd_data, 32'd2);
          check("R9 pulse on late fault", {31'd0, rst_req}, 32'd1);
        end
      end
      check("R5 late fault seen", {31'd0, seen}, 32'd1);
    end
    phase = "R8"; wr(3'd0, 32'h0000_0221);
    check("R8 irq masked", {31'd0, irq}, 32'd0);
    phase = "R1"; wr(3'd0, 32'h0000_0000); wr(3'd3, 32'd3);
    wr(3'd2, 32'hA5); wr(3'd2, 32'h5A);
    rd_chk("R1 service ignored while off", 3'd3, 32'd0);
    rd_chk("R1 count zero while off", 3'd4, 32'd0);
    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule